// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs the station-management side of an MII management link. Software writes a single 32-bit management word that carries the operation, the PHY address, the PHY register number and, for a write, the 16 data bits. If the port is enabled and no transfer is running, that one write launches a complete frame. The frame goes out on MDC/MDIO: a preamble of ones, the start pattern, the opcode, both addresses, the turnaround and then the data.

On a read, the controller releases MDIO from the turnaround onward. It samples the PHY's answer on each rising MDC edge, and the 16 received bits then overwrite the low half of the management word. Software learns that the transfer has finished by polling an idle flag.

MDC is divided down from the system clock. A control bit chooses between a fast divisor (a parameter) and a divide-by-32 setting. The register port is a plain write strobe with an address, plus a combinational read-back mux.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the idle flag (status address 2, bit 0) reads 1, MDC is 0, MDIO is not driven, and the control register (address 0) reads 0.
- R2: The management word (address 1) holds the opcode in bits 29:28, the PHY address in 27:23, the register number in 22:18 and the data in 15:0. The frame is sent MSB first as 32 ones, then 01, the opcode, the PHY address, the register number, the turnaround and the 16 data bits. That is 64 bit periods.
- R3: Control bit 1 selects the MDC period: 0 gives FAST_DIV system clocks and 1 gives 32. Each bit period starts with MDC low for the first half and high for the second half. MDC stays low while idle.
- R4: For any opcode other than 10, the block drives MDIO for all 64 bits, with turnaround 10 and the word's data bits.
- R5: For opcode 10 (read), MDIO is released from the first turnaround bit to the end of the frame. It is sampled on each rising MDC edge during the 16 data bits.
- R6: When a read completes, the sampled bits replace bits 15:0 of the management word MSB first. Bits 31:16 keep their values.
- R7: The idle flag is 0 from the cycle after an accepted word write until the cycle after the last data bit period ends.
- R8: A write to the management word while a frame is running is ignored. The word and the frame on the wire are unchanged.
- R9: Control bit 0 enables the port. While it is 0, a word write stores the value but starts no frame: idle stays 1 and MDC stays low.
- R10: While idle, MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 management word, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when mdio_oe is 1 |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
A behavioural reference in the bench predicts MDC, MDIO and its enable every clock. It is run against a write frame at the fast divisor and against two read frames with different PHY answers, one at each divisor.

The two read answers (A5C3 and 1234) use unlike bit patterns, so a wrong sampling edge or bit order shows up. Setting the word's top bits on a read shows whether the upper half is preserved.

Two further cases are covered. A word write during a running read tells an ignored write apart from one that corrupts the word. A write with the port disabled tells storage apart from frame start.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_WORD = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] SOF_BITS  = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;
  localparam logic [1:0] TA_READ   = 2'b11;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SLOW_BIT = 1;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic mdc,
  output logic rise_tick,
  output logic end_tick
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] FAST_FULL = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] FAST_HALF = CW'(FAST_DIV / 2 - 1);
  localparam logic [CW-1:0] SLOW_FULL = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] SLOW_HALF = CW'(SLOW_DIV / 2 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] full_m1;
  logic [CW-1:0] half_m1;

  always_comb begin
    full_m1   = slow ? SLOW_FULL : FAST_FULL;
    half_m1   = slow ? SLOW_HALF : FAST_HALF;
    rise_tick = run && (cnt == half_m1);
    end_tick  = run && (cnt == full_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= end_tick ? '0 : cnt + 1'b1;
      if (rise_tick)     mdc <= 1'b1;
      else if (end_tick) mdc <= 1'b0;
    end
  end

  // R3: the management clock rests low whenever no frame runs
  assert_mdc_low_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int PRE_LEN = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [PRE_LEN+31:0]     frame_in,
  input  logic                    is_read,
  input  logic                    rise_tick,
  input  logic                    end_tick,
  input  logic                    mdio_i,
  output logic                    busy,
  output logic                    mdio_o,
  output logic                    mdio_oe,
  output logic [15:0]             rd_data,
  output logic                    done
);
  localparam int FL = PRE_LEN + 32;
  localparam int BW = $clog2(FL);
  localparam logic [BW-1:0] LAST_IDX = BW'(FL - 1);
  localparam logic [BW-1:0] TA_IDX   = BW'(PRE_LEN + 14);
  localparam logic [BW-1:0] DATA_IDX = BW'(PRE_LEN + 16);
  localparam logic [BW-1:0] SOF_IDX  = BW'(PRE_LEN);

  logic [FL-1:0] shreg;
  logic [BW-1:0] bit_idx;
  logic          read_q;
  logic [BW-1:0] next_idx;

  assign next_idx = bit_idx + 1'b1;
  assign done     = busy && end_tick && (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      read_q  <= 1'b0;
      rd_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      shreg   <= frame_in;
      bit_idx <= '0;
      read_q  <= is_read;
      mdio_o  <= frame_in[FL-1];
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tick && read_q && (bit_idx >= DATA_IDX))
        rd_data <= {rd_data[14:0], mdio_i};
      if (end_tick) begin
        if (bit_idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= next_idx;
          shreg   <= {shreg[FL-2:0], 1'b0};
          mdio_o  <= shreg[FL-2];
          mdio_oe <= !(read_q && (next_idx >= TA_IDX));
        end
      end
    end
  end

  // R2: preamble bits are driven ones
  assert_preamble_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && (bit_idx < SOF_IDX)) |-> (mdio_o && mdio_oe));
  // R2: start pattern 0 then 1
  assert_sof_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && (bit_idx == SOF_IDX)) |-> !mdio_o);
  // R5: read frames release the line from the turnaround on
  assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && read_q && (bit_idx >= TA_IDX)) |-> !mdio_oe);
  // R10: line not driven while idle
  assert_idle_hiz_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 32,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_mgmt_pkg::*;

  localparam int FL = PRE_LEN + 32;

  logic        port_en;
  logic        slow_sel;
  logic        slow_q;
  logic        read_q;
  logic [31:0] mgmt_word;
  logic        busy;
  logic        done;
  logic        start;
  logic        wr_word;
  logic        wr_is_read;
  logic [FL-1:0] frame;
  logic [15:0] rd_data;
  logic        rise_tick;
  logic        end_tick;

  assign wr_word    = reg_wr_en && (reg_addr == ADDR_WORD);
  assign wr_is_read = (reg_wdata[29:28] == OP_READ);
  assign start      = wr_word && !busy && port_en;
  assign frame      = {{PRE_LEN{1'b1}}, SOF_BITS, reg_wdata[29:18],
                       (wr_is_read ? TA_READ : TA_WRITE), reg_wdata[15:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      port_en   <= 1'b0;
      slow_sel  <= 1'b0;
      slow_q    <= 1'b0;
      read_q    <= 1'b0;
      mgmt_word <= '0;
    end else begin
      if (reg_wr_en && (reg_addr == ADDR_CTRL)) begin
        port_en  <= reg_wdata[CTRL_EN_BIT];
        slow_sel <= reg_wdata[CTRL_SLOW_BIT];
      end
      if (wr_word && !busy)
        mgmt_word <= reg_wdata;
      else if (done && read_q)
        mgmt_word[15:0] <= rd_data;
      if (start) begin
        slow_q <= slow_sel;
        read_q <= wr_is_read;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {30'd0, slow_sel, port_en};
      ADDR_WORD: reg_rdata = mgmt_word;
      ADDR_STAT: reg_rdata = {31'd0, !busy};
      default:   reg_rdata = '0;
    endcase
  end

  mdio_clk_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_clk_gen (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .slow      (slow_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .end_tick  (end_tick)
  );

  mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .frame_in  (frame),
    .is_read   (wr_is_read),
    .rise_tick (rise_tick),
    .end_tick  (end_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data),
    .done      (done)
  );

  // R8: a word write during a frame leaves the word untouched
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_word && busy && !done) |=> $stable(mgmt_word));
  // R9: a frame only begins while the port is enabled
  assert_start_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(port_en));
  // R6: completion of a read keeps the upper half
  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (done && read_q) |=> (mgmt_word[31:16] == $past(mgmt_word[31:16])));
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  // reference model state
  bit          m_busy, m_mdc, m_read, m_en, m_slow;
  int          m_cnt, m_bit, m_div;
  logic [63:0] m_frame;
  logic [31:0] m_word;
  logic [15:0] m_cap;
  logic [15:0] phy_val = 16'h0000;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) begin
    bit pre_busy;
    if (rst) begin
      m_busy = 0; m_mdc = 0; m_read = 0; m_en = 0; m_slow = 0;
      m_cnt = 0; m_bit = 0; m_div = 8; m_frame = '0; m_word = '0; m_cap = '0;
    end else begin
      pre_busy = m_busy;
      if (m_busy) begin
        if (m_cnt == m_div / 2 - 1) begin
          m_mdc = 1;
          if (m_read && m_bit >= 48) m_cap = {m_cap[14:0], mdio_i};
        end
        if (m_cnt == m_div - 1) begin
          m_mdc = 0;
          m_cnt = 0;
          if (m_bit == 63) begin
            m_busy = 0;
            if (m_read) m_word[15:0] = m_cap;
          end else m_bit++;
        end else m_cnt++;
      end
      if (reg_wr_en && reg_addr == 2'd0) begin
        m_en = reg_wdata[0];
        m_slow = reg_wdata[1];
      end
      if (reg_wr_en && reg_addr == 2'd1 && !pre_busy) begin
        m_word = reg_wdata;
        if (m_en) begin
          m_read = (reg_wdata[29:28] == 2'b10);
          m_frame = {32'hFFFF_FFFF, 2'b01, reg_wdata[29:18],
                     (m_read ? 2'b11 : 2'b10), reg_wdata[15:0]};
          m_div = m_slow ? 32 : 8;
          m_busy = 1; m_cnt = 0; m_bit = 0; m_mdc = 0;
        end
      end
    end
  end

  // PHY side: answers read data bits, holds the line high otherwise
  always @(negedge clk) begin
    if (m_busy && m_read && m_bit >= 48) mdio_i <= phy_val[63 - m_bit];
    else if (m_busy && m_read && m_bit == 47) mdio_i <= 1'b0;
    else mdio_i <= 1'b1;
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    bit exp_oe;
    if (cmp_on && !finished) begin
      exp_oe = m_busy && !(m_read && m_bit >= 46);
      checks++;
      if (mdc !== m_mdc) begin
        errors++;
        $display("FAIL R3 mdc bit %0d: actual %b expected %b", m_bit, mdc, m_mdc);
      end
      checks++;
      if (mdio_oe !== exp_oe) begin
        errors++;
        $display("FAIL R4/R5/R10 mdio_oe bit %0d: actual %b expected %b", m_bit, mdio_oe, exp_oe);
      end
      if (exp_oe) begin
        checks++;
        if (mdio_o !== m_frame[63 - m_bit]) begin
          errors++;
          $display("FAIL R2 mdio_o bit %0d: actual %b expected %b", m_bit, mdio_o, m_frame[63 - m_bit]);
        end
      end
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check32(tag, reg_rdata, exp);
    reg_addr = 2'd2;
  endtask

  // R7: track idle flag until the frame ends, then one more look
  task automatic wait_frame();
    for (int n = 0; n < 4000 && m_busy; n++) begin
      @(negedge clk);
      #1 check32("R7 idle flag", reg_rdata, {31'd0, !m_busy});
    end
    @(negedge clk);
    #1 check32("R7 idle after frame", reg_rdata, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    // R1 reset state
    @(negedge clk);
    #1 check32("R1 status", reg_rdata, 32'd1);
    check32("R1 mdc/oe", {30'd0, mdc, mdio_oe}, 32'd0);
    rd(2'd0, "R1 control", 32'd0);

    // R4 write frame, fast divisor
    wr(2'd0, 32'h1);
    wr(2'd1, {2'b00, 2'b01, 5'h11, 5'h0A, 2'b00, 16'hBEEF});
    wait_frame();
    rd(2'd1, "R4 word after write frame", {2'b00, 2'b01, 5'h11, 5'h0A, 2'b00, 16'hBEEF});

    // R5 R6 read frame, fast divisor, upper bits set
    phy_val = 16'hA5C3;
    wr(2'd1, {2'b11, 2'b10, 5'h03, 5'h01, 2'b01, 16'h0000});
    repeat (40) @(negedge clk);
    // R8 write during frame is ignored
    wr(2'd1, 32'h1000_FFFF);
    wait_frame();
    rd(2'd1, "R6 R8 read result", {2'b11, 2'b10, 5'h03, 5'h01, 2'b01, 16'hA5C3});

    // R3 slow divisor read
    phy_val = 16'h1234;
    wr(2'd0, 32'h3);
    rd(2'd0, "R3 control readback", 32'h3);
    wr(2'd1, {2'b00, 2'b10, 5'h1F, 5'h1F, 2'b00, 16'hFFFF});
    wait_frame();
    rd(2'd1, "R6 slow read result", {2'b00, 2'b10, 5'h1F, 5'h1F, 2'b00, 16'h1234});

    // R9 port disabled: stored, no frame
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1000_0055);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      #1 check32("R9 idle while disabled", reg_rdata, 32'd1);
      check32("R9 mdc low while disabled", {31'd0, mdc}, 32'd0);
    end
    rd(2'd1, "R9 word stored", 32'h1000_0055);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule